// File: doc/BRIEF.md
# ECC Memory Controller Register Block

This block is the software-visible control and status register file of an ECC memory controller. A host reaches it over a simple 32-bit word-addressed port: a select strobe, a write enable, a 13-bit byte address and write data, with read data returned in the same cycle. The register window holds nine 32-bit registers: enable, delay, fault status, video configuration, two fault-address words, diagnostic, and two event counters.

The error-checking logic of the memory controller reports faults through a one-cycle strobe. The strobe carries a correctable/uncorrectable flag, an 8-bit syndrome and two 32-bit words of fault information. The block records the first fault, flags any later ones as a multiple-error condition, and drives one level interrupt. The interrupt stays high until software writes the fault status register.

A parameter `IMPL` selects one of three implementation codes (0, 1, 2). The code decides which enable bits are writable, the identity nibble, and which enable bits survive a reset. Only implementation 0 decodes a four-byte diagnostic window at byte address 0x1000.

Top module: `ecc_ctrl_regs`

## Requirements
- R1: Addresses with bits [12:6] clear form the register window, indexed by address bits [5:2]. Index 0 is enable, 1 delay, 2 fault status, 3 video configuration, 4 and 5 fault address 0 and 1, 6 diagnostic, 7 and 8 event counters 0 and 1. Video configuration, diagnostic and both event counters store all 32 written bits, and each is held separately. Indexes 9 to 15, and any other address outside the decoded windows, read as zero and ignore writes. `bus_rdata` is zero unless `bus_sel` is high and `bus_we` is low.
- R2: With `IMPL` = 0, a write to enable stores `wdata & 0x00000103`, and bits [31:28] read 0.
- R3: With `IMPL` = 1 or 2, a write to enable stores `wdata & 0x00000BFF`, and bits [31:28] always read the implementation code.
- R4: A write to delay stores `wdata & 0x7FFFFFFF`, so bit 31 always reads 0.
- R5: Bus writes to fault address 0 and fault address 1 have no effect.
- R6: An error strobe arriving while fault status bits 0 and 3 are both clear does the following:
  - sets bit 3 if the error is uncorrectable, otherwise sets bit 0;
  - writes the syndrome into bits [15:8];
  - loads the two information words into fault address 0 and 1.
  
  If bit 0 or bit 3 is already set, the strobe sets bit 16 and leaves the captured syndrome and addresses unchanged. Capture happens whatever the enable bits are.
- R7: A bus write to fault status stores the written value and drops `irq` on the next clock. If an error strobe arrives in the same cycle, the strobe is applied on top of the written value and the strobe's interrupt wins.
- R8: An error strobe raises `irq` on the next clock in two cases: the error is uncorrectable and enable bit 0 is set, or the error is correctable and enable bits 0 and 1 are both set. In every other case `irq` does not rise.
- R9: A synchronous reset keeps some enable bits and clears the rest. It keeps only bit 8 for `IMPL` = 0, and keeps bits [31:24], [9:2] and 11 for the other codes.
- R10: Reset sets delay to 0x00000020, fault address 0 to 0x07C00000, and fault status, video configuration, fault address 1, diagnostic and both event counters to zero. It also clears `irq`.
- R11: With `IMPL` = 0, the four byte addresses 0x1000 to 0x1003 form a byte-wide store. Each byte stores `wdata[7:0]` and reads back zero-extended, selected by address bits [1:0]. With any other code, that range reads zero and ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Access strobe for the register port |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 13 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| err_valid | input | 1 | One-cycle error report strobe |
| err_uncorr | input | 1 | 1 = uncorrectable, 0 = correctable |
| err_syndrome | input | 8 | Syndrome of the reported error |
| err_info0 | input | 32 | Fault information captured into fault address 0 |
| err_info1 | input | 32 | Fault information captured into fault address 1 |
| irq | output | 1 | Level interrupt |

## Verification
The bench writes all-ones to every register and reads each back. A wrong enable, delay or fault-address mask then shows up as a stray bit in the readback, and a missing identity nibble reads as a zero upper field. A second fault is reported while the first is still latched. A design that overwrites the capture returns the new syndrome and addresses, and one that forgets the multiple-error flag leaves bit 16 clear. Correctable faults are sent with the interrupt enable both off and on, an uncorrectable fault is sent with checking disabled, and a status write is made in the same cycle as a fault. A design with the wrong interrupt gating raises or misses `irq` in one of these cases, and one that lets the write win loses the fault. A reset after writing all-ones to enable exposes a wrong retention mask. The diagnostic window is probed on both implementation codes, so a design that decodes it on the wrong code reads back data instead of zero.

// File: rtl/ecc_regs_pkg.sv
package ecc_regs_pkg;

    localparam int unsigned DATA_W    = 32;
    localparam int unsigned ADDR_W    = 13;
    localparam int unsigned NUM_REGS  = 9;
    localparam int unsigned IDX_W     = 4;
    localparam int unsigned SYN_W     = 8;
    localparam int unsigned DIAG_BYTES = 4;
    localparam int unsigned DIAG_SEL_W = $clog2(DIAG_BYTES);
    localparam logic [ADDR_W-1:0] DIAG_BASE = 13'h1000;

    typedef enum logic [IDX_W-1:0] {
        IX_ENABLE = 4'd0,
        IX_DELAY  = 4'd1,
        IX_FSTAT  = 4'd2,
        IX_VIDCFG = 4'd3,
        IX_FADDR0 = 4'd4,
        IX_FADDR1 = 4'd5,
        IX_DIAG   = 4'd6,
        IX_EVT0   = 4'd7,
        IX_EVT1   = 4'd8
    } reg_ix_e;

    localparam logic [DATA_W-1:0] DELAY_WMASK = 32'h7FFF_FFFF;
    localparam logic [DATA_W-1:0] DELAY_RST   = 32'h0000_0020;
    localparam logic [DATA_W-1:0] FADDR0_RST  = 32'h07C0_0000;

    // fault status bit positions (decoded by software)
    localparam int unsigned FS_CE     = 0;
    localparam int unsigned FS_UE     = 3;
    localparam int unsigned FS_SYN_LO = 8;
    localparam int unsigned FS_ME     = 16;

    typedef struct packed {
        logic              valid;
        logic              uncorr;
        logic [SYN_W-1:0]  syn;
        logic [DATA_W-1:0] info0;
        logic [DATA_W-1:0] info1;
    } err_rpt_t;

    typedef struct packed {
        logic              rd;
        logic              wr;
        logic [DATA_W-1:0] wdata;
    } bus_op_t;

    function automatic logic [DATA_W-1:0] en_wmask(input int unsigned impl);
        return (impl == 0) ? 32'h0000_0103 : 32'h0000_0BFF;
    endfunction

    function automatic logic [DATA_W-1:0] en_keep(input int unsigned impl);
        return (impl == 0) ? 32'h0000_0100 : 32'hFF00_0BFC;
    endfunction

    function automatic logic [DATA_W-1:0] en_ident(input int unsigned impl);
        logic [3:0] code;
        code = 4'(impl);
        return (impl == 0) ? '0 : {code, 28'h0};
    endfunction

endpackage

// File: rtl/ecc_addr_decode.sv
module ecc_addr_decode
    import ecc_regs_pkg::*;
#(
    parameter int unsigned AW    = ADDR_W,
    parameter int unsigned NR    = NUM_REGS,
    parameter int unsigned IW    = IDX_W,
    parameter int unsigned SELW  = DIAG_SEL_W
) (
    input  logic [AW-1:0]   addr,
    output logic [NR-1:0]   reg_hit,
    output logic [IW-1:0]   idx,
    output logic            diag_hit,
    output logic [SELW-1:0] byte_sel
);
    localparam int unsigned LO = IW + 2;

    logic reg_win;

    assign reg_win  = (addr[AW-1:LO] == '0);
    assign idx      = addr[LO-1:2];
    assign diag_hit = (addr[AW-1:SELW] == DIAG_BASE[AW-1:SELW]);
    assign byte_sel = addr[SELW-1:0];

    for (genvar g = 0; g < NR; g++) begin : g_hit
        assign reg_hit[g] = reg_win && (idx == IW'(g));
    end
endmodule

// File: rtl/ecc_fault_capture.sv
module ecc_fault_capture
    import ecc_regs_pkg::*;
#(
    parameter int unsigned DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst,
    input  err_rpt_t      rpt,
    input  logic          fs_wr,
    input  logic [DW-1:0] wdata,
    input  logic          ecc_en,
    input  logic          ce_irq_en,
    output logic [DW-1:0] fstat,
    output logic [DW-1:0] faddr0,
    output logic [DW-1:0] faddr1,
    output logic          irq
);
    logic [DW-1:0] fstat_q, faddr0_q, faddr1_q;
    logic [DW-1:0] base, fstat_n;
    logic          irq_q, busy, load, raise;

    always_comb begin
        base    = fs_wr ? wdata : fstat_q;
        busy    = base[FS_CE] | base[FS_UE];
        load    = rpt.valid && !busy;
        fstat_n = base;
        if (rpt.valid) begin
            if (busy) begin
                fstat_n[FS_ME] = 1'b1;
            end else begin
                fstat_n[FS_UE] = rpt.uncorr;
                fstat_n[FS_CE] = ~rpt.uncorr;
                fstat_n[FS_SYN_LO +: SYN_W] = rpt.syn;
            end
        end
        raise = rpt.valid && ecc_en && (rpt.uncorr || ce_irq_en);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fstat_q  <= '0;
            faddr0_q <= FADDR0_RST;
            faddr1_q <= '0;
            irq_q    <= 1'b0;
        end else begin
            fstat_q <= fstat_n;
            if (load) begin
                faddr0_q <= rpt.info0;
                faddr1_q <= rpt.info1;
            end
            if (raise)      irq_q <= 1'b1;
            else if (fs_wr) irq_q <= 1'b0;
        end
    end

    assign fstat  = fstat_q;
    assign faddr0 = faddr0_q;
    assign faddr1 = faddr1_q;
    assign irq    = irq_q;

    // R7
    irq_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (fs_wr && !rpt.valid) |=> !irq_q);

    // R6
    me_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (rpt.valid && !fs_wr && (fstat_q[FS_CE] || fstat_q[FS_UE]))
        |=> (fstat_q[FS_ME] && $stable(faddr0_q) && $stable(faddr1_q)));

    // R5
    faddr_ro_chk: assert property (@(posedge clk) disable iff (rst)
        !rpt.valid |=> ($stable(faddr0_q) && $stable(faddr1_q)));

    // R8
    ue_irq_chk: assert property (@(posedge clk) disable iff (rst)
        (rpt.valid && rpt.uncorr && ecc_en) |=> irq_q);

    // R8
    ce_mask_chk: assert property (@(posedge clk) disable iff (rst)
        (rpt.valid && !rpt.uncorr && !ce_irq_en && !irq_q) |=> !irq_q);
endmodule

// File: rtl/ecc_diag_window.sv
module ecc_diag_window
    import ecc_regs_pkg::*;
#(
    parameter int unsigned IMPL  = 1,
    parameter int unsigned NB    = DIAG_BYTES,
    parameter int unsigned SELW  = DIAG_SEL_W
) (
    input  logic            clk,
    input  logic            wr,
    input  logic [SELW-1:0] sel,
    input  logic [7:0]      wbyte,
    output logic [7:0]      rbyte
);
    if (IMPL == 0) begin : g_store
        logic [7:0] mem_q [NB];
        for (genvar b = 0; b < NB; b++) begin : g_byte
            always_ff @(posedge clk) begin
                if (wr && (sel == SELW'(b))) mem_q[b] <= wbyte;
            end
        end
        assign rbyte = mem_q[sel];
    end else begin : g_absent
        logic unused;
        assign unused = clk ^ wr ^ (^sel) ^ (^wbyte);
        assign rbyte  = '0;
    end
endmodule

// File: rtl/ecc_ctrl_regs.sv
module ecc_ctrl_regs
    import ecc_regs_pkg::*;
#(
    parameter int unsigned IMPL = 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 bus_sel,
    input  logic                 bus_we,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [DATA_W-1:0]    bus_wdata,
    output logic [DATA_W-1:0]    bus_rdata,
    input  logic                 err_valid,
    input  logic                 err_uncorr,
    input  logic [SYN_W-1:0]     err_syndrome,
    input  logic [DATA_W-1:0]    err_info0,
    input  logic [DATA_W-1:0]    err_info1,
    output logic                 irq
);
    localparam logic [DATA_W-1:0] EN_WMASK = en_wmask(IMPL);
    localparam logic [DATA_W-1:0] EN_KEEP  = en_keep(IMPL);
    localparam logic [DATA_W-1:0] EN_IDENT = en_ident(IMPL);
    localparam logic [3:0]        IMPL_ID  = 4'(IMPL);
    localparam int unsigned       NEVT     = 2;

    bus_op_t               op;
    err_rpt_t              rpt;
    logic [NUM_REGS-1:0]   reg_hit;
    logic [IDX_W-1:0]      idx;
    logic                  diag_hit;
    logic [DIAG_SEL_W-1:0] byte_sel;
    logic [7:0]            diag_byte;
    logic [DATA_W-1:0]     fstat, faddr0, faddr1;
    logic [DATA_W-1:0]     rd_mux;

    // enable bits that are retained over reset start from a defined value
    logic [DATA_W-1:0] en_q = EN_IDENT;
    logic [DATA_W-1:0] dly_q, vid_q, dgr_q;
    logic [DATA_W-1:0] evt_q [NEVT];

    assign op.rd    = bus_sel && !bus_we;
    assign op.wr    = bus_sel && bus_we;
    assign op.wdata = bus_wdata;

    assign rpt.valid  = err_valid;
    assign rpt.uncorr = err_uncorr;
    assign rpt.syn    = err_syndrome;
    assign rpt.info0  = err_info0;
    assign rpt.info1  = err_info1;

    ecc_addr_decode u_dec (
        .addr     (bus_addr),
        .reg_hit  (reg_hit),
        .idx      (idx),
        .diag_hit (diag_hit),
        .byte_sel (byte_sel)
    );

    ecc_fault_capture u_flt (
        .clk       (clk),
        .rst       (rst),
        .rpt       (rpt),
        .fs_wr     (op.wr && reg_hit[IX_FSTAT]),
        .wdata     (op.wdata),
        .ecc_en    (en_q[0]),
        .ce_irq_en (en_q[1]),
        .fstat     (fstat),
        .faddr0    (faddr0),
        .faddr1    (faddr1),
        .irq       (irq)
    );

    ecc_diag_window #(.IMPL(IMPL)) u_diag (
        .clk   (clk),
        .wr    (op.wr && diag_hit),
        .sel   (byte_sel),
        .wbyte (op.wdata[7:0]),
        .rbyte (diag_byte)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q  <= (en_q & EN_KEEP) | EN_IDENT;
            dly_q <= DELAY_RST;
            vid_q <= '0;
            dgr_q <= '0;
        end else if (op.wr) begin
            if (reg_hit[IX_ENABLE]) en_q  <= EN_IDENT | (op.wdata & EN_WMASK);
            if (reg_hit[IX_DELAY])  dly_q <= op.wdata & DELAY_WMASK;
            if (reg_hit[IX_VIDCFG]) vid_q <= op.wdata;
            if (reg_hit[IX_DIAG])   dgr_q <= op.wdata;
        end
    end

    for (genvar e = 0; e < NEVT; e++) begin : g_evt
        always_ff @(posedge clk) begin
            if (rst)                                          evt_q[e] <= '0;
            else if (op.wr && reg_hit[int'(IX_EVT0) + e])     evt_q[e] <= op.wdata;
        end
    end

    always_comb begin
        rd_mux = '0;
        if (diag_hit) begin
            rd_mux = {{(DATA_W-8){1'b0}}, diag_byte};
        end else if (|reg_hit) begin
            case (idx)
                IX_ENABLE: rd_mux = en_q;
                IX_DELAY:  rd_mux = dly_q;
                IX_FSTAT:  rd_mux = fstat;
                IX_VIDCFG: rd_mux = vid_q;
                IX_FADDR0: rd_mux = faddr0;
                IX_FADDR1: rd_mux = faddr1;
                IX_DIAG:   rd_mux = dgr_q;
                IX_EVT0:   rd_mux = evt_q[0];
                IX_EVT1:   rd_mux = evt_q[1];
                default:   rd_mux = '0;
            endcase
        end
    end

    assign bus_rdata = op.rd ? rd_mux : '0;

    // R2 R3
    ident_chk: assert property (@(posedge clk) disable iff (rst)
        (op.rd && reg_hit[IX_ENABLE]) |-> (bus_rdata[31:28] == IMPL_ID));

    // R4
    dly_top_chk: assert property (@(posedge clk) disable iff (rst)
        (op.rd && reg_hit[IX_DELAY]) |-> !bus_rdata[31]);

    // R1
    idle_rdata_chk: assert property (@(posedge clk) disable iff (rst)
        !op.rd |-> (bus_rdata == '0));

    if (IMPL != 0) begin : g_nodiag_chk
        // R11
        nodiag_chk: assert property (@(posedge clk) disable iff (rst)
            (op.rd && diag_hit) |-> (bus_rdata == '0));
    end
endmodule

// File: tb/ecc_ctrl_regs_tb.sv
module ecc_ctrl_regs_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sel1 = 1'b0, sel0 = 1'b0, we = 1'b0;
    logic [12:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata1, rdata0;
    logic        ev = 1'b0, ue = 1'b0;
    logic [7:0]  syn = '0;
    logic [31:0] i0 = '0, i1 = '0;
    logic        irq1, irq0;
    int          checks = 0, fails = 0;

    always #10 clk = ~clk;

    ecc_ctrl_regs #(.IMPL(1)) dut_i (
        .clk(clk), .rst(rst), .bus_sel(sel1), .bus_we(we), .bus_addr(addr),
        .bus_wdata(wdata), .bus_rdata(rdata1), .err_valid(ev), .err_uncorr(ue),
        .err_syndrome(syn), .err_info0(i0), .err_info1(i1), .irq(irq1));

    ecc_ctrl_regs #(.IMPL(0)) dut_m_i (
        .clk(clk), .rst(rst), .bus_sel(sel0), .bus_we(we), .bus_addr(addr),
        .bus_wdata(wdata), .bus_rdata(rdata0), .err_valid(ev), .err_uncorr(ue),
        .err_syndrome(syn), .err_info0(i0), .err_info1(i1), .irq(irq0));

    // {write, addr, wdata, expected readback} for the IMPL=1 instance
    localparam int NV = 15;
    localparam logic [96:0] VEC [NV] = '{
        {1'b1, 32'h0000, 32'hFFFF_FFFF, 32'h1000_0BFF},  // R3
        {1'b1, 32'h0004, 32'hFFFF_FFFF, 32'h7FFF_FFFF},  // R4
        {1'b1, 32'h000C, 32'hA5A5_5A5A, 32'hA5A5_5A5A},  // R1
        {1'b1, 32'h0018, 32'h1234_5678, 32'h1234_5678},  // R1
        {1'b1, 32'h001C, 32'hCAFE_F00D, 32'hCAFE_F00D},  // R1
        {1'b1, 32'h0020, 32'h0BAD_BEEF, 32'h0BAD_BEEF},  // R1
        {1'b0, 32'h001C, 32'h0000_0000, 32'hCAFE_F00D},  // R1
        {1'b1, 32'h0010, 32'hFFFF_FFFF, 32'h07C0_0000},  // R5
        {1'b1, 32'h0014, 32'hFFFF_FFFF, 32'h0000_0000},  // R5
        {1'b1, 32'h0024, 32'hFFFF_FFFF, 32'h0000_0000},  // R1
        {1'b1, 32'h003C, 32'hFFFF_FFFF, 32'h0000_0000},  // R1
        {1'b1, 32'h0040, 32'hFFFF_FFFF, 32'h0000_0000},  // R1
        {1'b1, 32'h1000, 32'h0000_00FF, 32'h0000_0000},  // R11
        {1'b1, 32'h0008, 32'h0000_0F00, 32'h0000_0F00},  // R7
        {1'b1, 32'h0000, 32'h0000_0000, 32'h1000_0000}   // R3
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input bit m, input logic [12:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; we = 1'b1;
        if (m) sel0 = 1'b1; else sel1 = 1'b1;
        @(negedge clk);
        sel0 = 1'b0; sel1 = 1'b0; we = 1'b0;
    endtask

    task automatic rd(input bit m, input logic [12:0] a, output logic [31:0] d);
        @(negedge clk);
        addr = a; we = 1'b0;
        if (m) sel0 = 1'b1; else sel1 = 1'b1;
        #1 d = m ? rdata0 : rdata1;
        sel0 = 1'b0; sel1 = 1'b0;
    endtask

    task automatic rchk(input bit m, input logic [12:0] a, input logic [31:0] exp, input string req);
        logic [31:0] v;
        rd(m, a, v);
        chk(req, v, exp);
    endtask

    // error strobe for one cycle, optionally with a fault-status write on the same edge
    task automatic err(input logic u, input logic [7:0] s, input logic [31:0] a0,
                       input logic [31:0] a1, input bit with_wr);
        @(negedge clk);
        ev = 1'b1; ue = u; syn = s; i0 = a0; i1 = a1;
        if (with_wr) begin sel1 = 1'b1; we = 1'b1; addr = 13'h0008; wdata = '0; end
        @(negedge clk);
        ev = 1'b0; sel1 = 1'b0; we = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1;
        @(negedge clk); @(negedge clk); rst = 1'b0;
    endtask

    initial begin
        #(20 * 150000);
        fails++;
        $display("FAIL watchdog actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R10 reset state
        rchk(0, 13'h0000, 32'h1000_0000, "R10 enable");
        rchk(0, 13'h0004, 32'h0000_0020, "R10 delay");
        rchk(0, 13'h0008, 32'h0, "R10 fstat");
        rchk(0, 13'h000C, 32'h0, "R10 vidcfg");
        rchk(0, 13'h0010, 32'h07C0_0000, "R10 faddr0");
        rchk(0, 13'h0014, 32'h0, "R10 faddr1");
        rchk(0, 13'h0018, 32'h0, "R10 diag");
        rchk(0, 13'h001C, 32'h0, "R10 evt0");
        rchk(0, 13'h0020, 32'h0, "R10 evt1");
        rchk(1, 13'h0000, 32'h0, "R10 impl0 enable");
        chk("R10 irq", {31'b0, irq1}, 32'h0);
        chk("R1 idle rdata", rdata1, 32'h0);

        for (int k = 0; k < NV; k++) begin
            if (VEC[k][96]) wr(0, VEC[k][76:64], VEC[k][63:32]);
            rchk(0, VEC[k][76:64], VEC[k][31:0], "R1-R5 vector");
        end

        // R2 implementation 0 mask and identity
        wr(1, 13'h0000, 32'hFFFF_FFFF);
        rchk(1, 13'h0000, 32'h0000_0103, "R2");

        // R9 retention
        wr(0, 13'h0000, 32'hFFFF_FFFF);
        wr(0, 13'h000C, 32'h1111_2222);
        do_reset();
        rchk(0, 13'h0000, 32'h1000_0BFC, "R9 impl1");
        rchk(1, 13'h0000, 32'h0000_0100, "R9 impl0");
        rchk(0, 13'h000C, 32'h0, "R10 vidcfg after reset");

        // R6 R8 capture with correctable irq disabled
        wr(0, 13'h0000, 32'h0000_0001);
        err(1'b0, 8'h5A, 32'h1111_2222, 32'h3333_4444, 0);
        chk("R8 ce masked", {31'b0, irq1}, 32'h0);
        rchk(0, 13'h0008, 32'h0000_5A01, "R6 ce capture");
        rchk(0, 13'h0010, 32'h1111_2222, "R6 faddr0");
        rchk(0, 13'h0014, 32'h3333_4444, "R6 faddr1");
        err(1'b1, 8'h77, 32'hDEAD_0000, 32'h0000_BEEF, 0);
        chk("R8 ue irq", {31'b0, irq1}, 32'h1);
        rchk(0, 13'h0008, 32'h0001_5A01, "R6 multiple");
        rchk(0, 13'h0010, 32'h1111_2222, "R6 faddr0 held");
        rchk(0, 13'h0014, 32'h3333_4444, "R6 faddr1 held");
        wr(0, 13'h0008, 32'h0);
        chk("R7 irq cleared", {31'b0, irq1}, 32'h0);
        rchk(0, 13'h0008, 32'h0, "R7 fstat written");

        // R8 correctable with irq enable
        wr(0, 13'h0000, 32'h0000_0003);
        err(1'b0, 8'h11, 32'h1, 32'h2, 0);
        chk("R8 ce irq", {31'b0, irq1}, 32'h1);
        wr(0, 13'h0008, 32'h0);
        chk("R7 irq cleared 2", {31'b0, irq1}, 32'h0);

        // R8 checking disabled: capture still happens, no irq
        wr(0, 13'h0000, 32'h0);
        err(1'b1, 8'h3C, 32'hAAAA_0001, 32'hBBBB_0002, 0);
        chk("R8 disabled", {31'b0, irq1}, 32'h0);
        rchk(0, 13'h0008, 32'h0000_3C08, "R6 ue capture");

        // R7 write and error on the same edge
        wr(0, 13'h0000, 32'h0000_0001);
        err(1'b1, 8'hC3, 32'h5555_0000, 32'h6666_0000, 1);
        chk("R7 same-cycle irq", {31'b0, irq1}, 32'h1);
        rchk(0, 13'h0008, 32'h0000_C308, "R7 same-cycle fstat");
        rchk(0, 13'h0010, 32'h5555_0000, "R7 same-cycle faddr0");

        // R11 diagnostic window on implementation 0
        wr(1, 13'h1000, 32'hABCD_EF11);
        wr(1, 13'h1001, 32'h0000_0022);
        wr(1, 13'h1002, 32'h0000_0033);
        wr(1, 13'h1003, 32'hFFFF_FF44);
        rchk(1, 13'h1000, 32'h11, "R11 byte0");
        rchk(1, 13'h1001, 32'h22, "R11 byte1");
        rchk(1, 13'h1002, 32'h33, "R11 byte2");
        rchk(1, 13'h1003, 32'h44, "R11 byte3");
        rchk(1, 13'h1004, 32'h0, "R11 outside window");
        rchk(0, 13'h1003, 32'h0, "R11 impl1 absent");

        rd(0, 13'h0000, v);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule